// File: doc/BRIEF.md
# Packed SIMD Saturating ALU

This block is a lane-partitioned arithmetic unit for short-vector media work. Each operand is one data word, 64 bits by default. The word is read as eight byte lanes, four halfword lanes or two word lanes, and every lane is computed on its own. An opcode selects one of these operation families:

- add or subtract, each wrapping, saturating as signed or saturating as unsigned;
- lane shifts;
- bitwise logic;
- compares that return all-ones or all-zeros lane masks;
- halfword multiplies and a pairwise multiply-accumulate;
- narrowing packs with saturation;
- interleaving unpacks that widen the data.

The unit is used like one execute stage. When valid is high, the caller presents the two operands, the opcode and the lane size. The result appears in a register one clock later, together with a matching valid flag. When no valid input arrives, the registered result keeps its value.

Top module: `psat_alu`

## Requirements
- R1: After reset, out_valid and out_result are zero. out_valid equals in_valid delayed by one clock, and out_result is the result for the inputs registered at that edge. While in_valid is low, out_result holds its value.
- R2: Lane size encoding is 0 = 8-bit, 1 = 16-bit, 2 = 32-bit. Code 3 is reserved and gives a zero result for every size-dependent opcode (0-8, 13, 14, 20, 21). Opcode 0 is wrapping add and opcode 3 is wrapping subtract. No carry or borrow crosses a lane boundary.
- R3: Opcodes 1 (add) and 4 (subtract) saturate as signed: a lane that overflows is clamped to the most positive or most negative lane value.
- R4: Opcodes 2 (add) and 5 (subtract) saturate as unsigned: overflow clamps to all ones and underflow clamps to zero.
- R5: Opcodes 6 (logical left), 7 (logical right) and 8 (arithmetic right) shift every lane of in_a by the unsigned count in in_b[7:0]. A count at or above the lane width gives zero for the logical shifts and a copy of the sign bit for the arithmetic shift.
- R6: Opcodes 9 (AND), 10 (~in_a & in_b), 11 (OR) and 12 (XOR) act on all bits, and the size field has no effect on them.
- R7: Opcode 13 (equal) and opcode 14 (signed greater-than, in_a > in_b) set each result lane to all ones when the test is true and to zero when it is false.
- R8: Opcodes 15 and 16 multiply the four signed 16-bit lanes and return the low 16 bits (15) or the high 16 bits (16) of each 32-bit product. The size field is ignored.
- R9: Opcode 17 multiplies signed 16-bit lanes and adds products 2k and 2k+1 into 32-bit lane k, wrapping modulo 2^32. The size field is ignored.
- R10: Opcode 18 narrows signed lanes with signed saturation. Size 1 takes 16-bit lanes to 8 bits and size 2 takes 32-bit lanes to 16 bits; any other size gives zero. The in_a lanes fill the low half of the result and the in_b lanes fill the high half, in lane order.
- R11: Opcode 19 narrows in the same layout as opcode 18, but treats each source lane as signed and clamps it to the unsigned range of the narrow lane.
- R12: Opcode 20 interleaves the low-half lanes of in_a and in_b, and opcode 21 interleaves their high-half lanes. Result lane 2i comes from in_a and lane 2i+1 from in_b. With in_b zero, this zero-extends each lane to twice its width.
- R13: Opcodes 22 to 31 give a zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and opcode are valid this cycle |
| in_op | input | 5 | Opcode |
| in_size | input | 2 | Lane size code |
| in_a | input | DATA_W | First operand |
| in_b | input | DATA_W | Second operand; also supplies the shift count |
| out_valid | output | 1 | Registered result is valid |
| out_result | output | DATA_W | Registered result |

## Verification
The bench sweeps every opcode against every size code, using boundary operands and pseudo-random operands. Boundary operands include lanes at the signed and unsigned limits, equal operands and the most-negative times most-negative halfword product. The most likely bugs each fail these cases in a visible way. A carry that leaks into the next lane corrupts the neighbour lane on all-ones inputs. A sign-bit test that is one bit off sends saturated adds and packs to the wrong limit. A multiply-accumulate that saturates returns 0x7FFFFFFF in place of the wrapped 0x80000000. A separate sweep of shift counts from 0 to 40 catches a shifter that keeps low bits, or loses the sign, once the count reaches the lane width.

// File: rtl/psat_pkg.sv
package psat_pkg;

   typedef enum logic [4:0] {
      OP_ADD    = 5'd0,
      OP_ADDS   = 5'd1,
      OP_ADDUS  = 5'd2,
      OP_SUB    = 5'd3,
      OP_SUBS   = 5'd4,
      OP_SUBUS  = 5'd5,
      OP_SLL    = 5'd6,
      OP_SRL    = 5'd7,
      OP_SRA    = 5'd8,
      OP_AND    = 5'd9,
      OP_ANDN   = 5'd10,
      OP_OR     = 5'd11,
      OP_XOR    = 5'd12,
      OP_CMPEQ  = 5'd13,
      OP_CMPGT  = 5'd14,
      OP_MULLO  = 5'd15,
      OP_MULHI  = 5'd16,
      OP_MADD   = 5'd17,
      OP_PACKSS = 5'd18,
      OP_PACKUS = 5'd19,
      OP_UNPKLO = 5'd20,
      OP_UNPKHI = 5'd21
   } psat_op_e;

   typedef enum logic [1:0] {
      SZ_8   = 2'd0,
      SZ_16  = 2'd1,
      SZ_32  = 2'd2,
      SZ_RSV = 2'd3
   } psat_size_e;

endpackage

// File: rtl/psat_lane_unit.sv
module psat_lane_unit
   import psat_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int LW     = 8
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  psat_op_e          op,
   output logic [DATA_W-1:0] y
);
   localparam int NL = DATA_W / LW;
   localparam int HL = NL / 2;
   localparam logic [7:0] LW8 = 8'(LW);

   logic [7:0]        sh;
   logic [DATA_W-1:0] unp_lo, unp_hi;

   assign sh = b[7:0];

   for (genvar j = 0; j < HL; j++) begin : g_unp
      assign unp_lo[(2*j)*LW +: LW]   = a[j*LW +: LW];
      assign unp_lo[(2*j+1)*LW +: LW] = b[j*LW +: LW];
      assign unp_hi[(2*j)*LW +: LW]   = a[(j+HL)*LW +: LW];
      assign unp_hi[(2*j+1)*LW +: LW] = b[(j+HL)*LW +: LW];
   end

   for (genvar i = 0; i < NL; i++) begin : g_lane
      logic [LW-1:0] la, lb, r;
      logic [LW:0]   s_add, s_sub, u_add, u_sub;
      logic [LW-1:0] smax, smin;

      assign la   = a[i*LW +: LW];
      assign lb   = b[i*LW +: LW];
      assign smax = {1'b0, {(LW-1){1'b1}}};
      assign smin = {1'b1, {(LW-1){1'b0}}};

      always_comb begin
         s_add = {la[LW-1], la} + {lb[LW-1], lb};
         s_sub = {la[LW-1], la} - {lb[LW-1], lb};
         u_add = {1'b0, la} + {1'b0, lb};
         u_sub = {1'b0, la} - {1'b0, lb};
         case (op)
            OP_ADD:    r = u_add[LW-1:0];
            OP_SUB:    r = u_sub[LW-1:0];
            OP_ADDS:   r = (s_add[LW] != s_add[LW-1]) ? (s_add[LW] ? smin : smax)
                                                      : s_add[LW-1:0];
            OP_SUBS:   r = (s_sub[LW] != s_sub[LW-1]) ? (s_sub[LW] ? smin : smax)
                                                      : s_sub[LW-1:0];
            OP_ADDUS:  r = u_add[LW] ? '1 : u_add[LW-1:0];
            OP_SUBUS:  r = u_sub[LW] ? '0 : u_sub[LW-1:0];
            OP_SLL:    r = (sh >= LW8) ? '0 : (la << sh);
            OP_SRL:    r = (sh >= LW8) ? '0 : (la >> sh);
            OP_SRA:    r = (sh >= LW8) ? {LW{la[LW-1]}} : LW'($signed(la) >>> sh);
            OP_CMPEQ:  r = {LW{la == lb}};
            OP_CMPGT:  r = {LW{$signed(la) > $signed(lb)}};
            OP_UNPKLO: r = unp_lo[i*LW +: LW];
            OP_UNPKHI: r = unp_hi[i*LW +: LW];
            default:   r = '0;
         endcase
      end

      assign y[i*LW +: LW] = r;
   end

endmodule

// File: rtl/psat_pack.sv
module psat_pack #(
   parameter int DATA_W = 64,
   parameter int SW     = 16
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              uns,
   output logic [DATA_W-1:0] y
);
   localparam int DW   = SW / 2;
   localparam int N    = DATA_W / SW;
   localparam int HALF = DATA_W / 2;

   function automatic logic [DW-1:0] narrow(input logic [SW-1:0] v, input logic u);
      logic [DW-1:0] res;
      if (u) begin
         if (v[SW-1])              res = '0;
         else if (|v[SW-2:DW])     res = '1;
         else                      res = v[DW-1:0];
      end else begin
         if (!v[SW-1] && (|v[SW-2:DW-1]))      res = {1'b0, {(DW-1){1'b1}}};
         else if (v[SW-1] && !(&v[SW-2:DW-1])) res = {1'b1, {(DW-1){1'b0}}};
         else                                  res = v[DW-1:0];
      end
      return res;
   endfunction

   for (genvar i = 0; i < N; i++) begin : g_nar
      assign y[i*DW +: DW]        = narrow(a[i*SW +: SW], uns);
      assign y[HALF + i*DW +: DW] = narrow(b[i*SW +: SW], uns);
   end

endmodule

// File: rtl/psat_mul16.sv
module psat_mul16 #(
   parameter int DATA_W = 64
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] y_lo,
   output logic [DATA_W-1:0] y_hi,
   output logic [DATA_W-1:0] y_madd
);
   localparam int NH = DATA_W / 16;

   logic [31:0] prod [NH];

   for (genvar i = 0; i < NH; i++) begin : g_mul
      assign prod[i] = 32'($signed(a[i*16 +: 16]) * $signed(b[i*16 +: 16]));
      assign y_lo[i*16 +: 16] = prod[i][15:0];
      assign y_hi[i*16 +: 16] = prod[i][31:16];
   end

   for (genvar k = 0; k < NH/2; k++) begin : g_madd
      assign y_madd[k*32 +: 32] = prod[2*k] + prod[2*k+1];
   end

endmodule

// File: rtl/psat_alu.sv
module psat_alu
   import psat_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [4:0]        in_op,
   input  logic [1:0]        in_size,
   input  logic [DATA_W-1:0] in_a,
   input  logic [DATA_W-1:0] in_b,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_result
);
   localparam int NSZ = 3;

   initial begin
      assert (DATA_W >= 64 && DATA_W % 64 == 0)
         else $fatal(1, "psat_alu: DATA_W must be a positive multiple of 64");
   end

   psat_op_e          op_e;
   logic [DATA_W-1:0] lane_y [NSZ];
   logic [DATA_W-1:0] pk16_y, pk32_y, mlo_y, mhi_y, madd_y;
   logic [DATA_W-1:0] nxt;
   logic              pk_uns;

   assign op_e   = psat_op_e'(in_op);
   assign pk_uns = (op_e == OP_PACKUS);

   for (genvar g = 0; g < NSZ; g++) begin : g_size
      psat_lane_unit #(.DATA_W(DATA_W), .LW(8 << g)) u_lane (
         .a (in_a),
         .b (in_b),
         .op(op_e),
         .y (lane_y[g])
      );
   end

   psat_pack #(.DATA_W(DATA_W), .SW(16)) u_pk16 (
      .a(in_a), .b(in_b), .uns(pk_uns), .y(pk16_y)
   );

   psat_pack #(.DATA_W(DATA_W), .SW(32)) u_pk32 (
      .a(in_a), .b(in_b), .uns(pk_uns), .y(pk32_y)
   );

   psat_mul16 #(.DATA_W(DATA_W)) u_mul (
      .a(in_a), .b(in_b), .y_lo(mlo_y), .y_hi(mhi_y), .y_madd(madd_y)
   );

   always_comb begin
      case (op_e)
         OP_AND:   nxt = in_a & in_b;
         OP_ANDN:  nxt = ~in_a & in_b;
         OP_OR:    nxt = in_a | in_b;
         OP_XOR:   nxt = in_a ^ in_b;
         OP_MULLO: nxt = mlo_y;
         OP_MULHI: nxt = mhi_y;
         OP_MADD:  nxt = madd_y;
         OP_PACKSS, OP_PACKUS: begin
            case (psat_size_e'(in_size))
               SZ_16:   nxt = pk16_y;
               SZ_32:   nxt = pk32_y;
               default: nxt = '0;
            endcase
         end
         OP_ADD, OP_ADDS, OP_ADDUS, OP_SUB, OP_SUBS, OP_SUBUS,
         OP_SLL, OP_SRL, OP_SRA, OP_CMPEQ, OP_CMPGT,
         OP_UNPKLO, OP_UNPKHI: begin
            case (psat_size_e'(in_size))
               SZ_8:    nxt = lane_y[0];
               SZ_16:   nxt = lane_y[1];
               SZ_32:   nxt = lane_y[2];
               default: nxt = '0;
            endcase
         end
         default: nxt = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_result <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) out_result <= nxt;
      end
   end

endmodule

// File: rtl/psat_alu_chk.sv
module psat_alu_chk #(
   parameter int DATA_W = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [4:0]        in_op,
   input logic [1:0]        in_size,
   input logic [DATA_W-1:0] in_a,
   input logic [DATA_W-1:0] in_b,
   input logic              out_valid,
   input logic [DATA_W-1:0] out_result
);

   // R1: valid follows one cycle later
   a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   a_r1_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_result));

   // R2: reserved size zeroes size-dependent lane arithmetic
   a_r2_reserved_size: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_size == 2'd3 && in_op <= 5'd8) |=> (out_result == '0));

   // R4: unsigned saturation limits
   a_r4_addus_ones: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_op == 5'd2 && in_size != 2'd3 && (&in_a)) |=> (&out_result));

   a_r4_subus_self: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_op == 5'd5 && in_size != 2'd3 && in_a == in_b) |=> (out_result == '0));

   // R6: XOR of equal operands is zero
   a_r6_xor_self: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_op == 5'd12 && in_a == in_b) |=> (out_result == '0));

   // R7: equal operands give an all-ones mask
   a_r7_eq_self: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_op == 5'd13 && in_size != 2'd3 && in_a == in_b) |=> (&out_result));

   // R13: undefined opcodes give zero
   a_r13_undef: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_op > 5'd21) |=> (out_result == '0));

endmodule

bind psat_alu psat_alu_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_psat_alu.sv
`timescale 1ns/1ps
module tb_psat_alu;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [4:0]  in_op = '0;
   logic [1:0]  in_size = '0;
   logic [63:0] in_a = '0;
   logic [63:0] in_b = '0;
   logic        out_valid;
   logic [63:0] out_result;

   int checks = 0;
   int errors = 0;
   logic [63:0] rng = 64'h9E3779B97F4A7C15;

   always #2 clk = ~clk;

   psat_alu #(.DATA_W(64)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
      .in_size(in_size), .in_a(in_a), .in_b(in_b),
      .out_valid(out_valid), .out_result(out_result)
   );

   function automatic logic [63:0] nxt_rand(input logic [63:0] s);
      logic [63:0] x = s;
      x = x ^ (x << 13);
      x = x ^ (x >> 7);
      x = x ^ (x << 17);
      return x;
   endfunction

   function automatic logic [63:0] model(input int op, input int sz,
                                         input logic [63:0] a, input logic [63:0] b);
      logic [63:0] r = '0;
      logic [63:0] m;
      int lw, n, dw, sh;
      longint ua, ub, sa, sb, v, lo, hi, p0, p1;
      case (op)
         9:  return a & b;
         10: return ~a & b;
         11: return a | b;
         12: return a ^ b;
         15, 16: begin
            for (int i = 0; i < 4; i++) begin
               sa = longint'($signed(a[i*16 +: 16]));
               sb = longint'($signed(b[i*16 +: 16]));
               v  = sa * sb;
               if (op == 16) v = v >>> 16;
               r = r | ((64'(v) & 64'hFFFF) << (i*16));
            end
            return r;
         end
         17: begin
            for (int k = 0; k < 2; k++) begin
               p0 = longint'($signed(a[32*k +: 16]))      * longint'($signed(b[32*k +: 16]));
               p1 = longint'($signed(a[32*k+16 +: 16]))   * longint'($signed(b[32*k+16 +: 16]));
               r = r | ((64'(p0 + p1) & 64'hFFFF_FFFF) << (32*k));
            end
            return r;
         end
         default: ;
      endcase
      if (op > 21 || sz == 3) return '0;
      lw = 8 << sz;
      n  = 64 / lw;
      m  = (64'd1 << lw) - 64'd1;
      lo = -(longint'(1) << (lw-1));
      hi = (longint'(1) << (lw-1)) - 1;
      sh = int'(b[7:0]);
      if (op == 18 || op == 19) begin
         if (sz == 0) return '0;
         dw = lw / 2;
         for (int i = 0; i < n; i++) begin
            for (int side = 0; side < 2; side++) begin
               ua = longint'(((side == 0 ? a : b) >> (i*lw)) & m);
               v  = (ua > hi) ? ua - (longint'(1) << lw) : ua;
               if (op == 19) begin
                  if (v < 0) v = 0;
                  if (v > (longint'(1) << dw) - 1) v = (longint'(1) << dw) - 1;
               end else begin
                  if (v < -(longint'(1) << (dw-1))) v = -(longint'(1) << (dw-1));
                  if (v > (longint'(1) << (dw-1)) - 1) v = (longint'(1) << (dw-1)) - 1;
               end
               r = r | ((64'(v) & ((64'd1 << dw) - 64'd1)) << (side*32 + i*dw));
            end
         end
         return r;
      end
      if (op == 20 || op == 21) begin
         for (int i = 0; i < n/2; i++) begin
            int src = (op == 21) ? i + n/2 : i;
            r = r | (((a >> (src*lw)) & m) << ((2*i)*lw));
            r = r | (((b >> (src*lw)) & m) << ((2*i+1)*lw));
         end
         return r;
      end
      for (int i = 0; i < n; i++) begin
         ua = longint'((a >> (i*lw)) & m);
         ub = longint'((b >> (i*lw)) & m);
         sa = (ua > hi) ? ua - (longint'(1) << lw) : ua;
         sb = (ub > hi) ? ub - (longint'(1) << lw) : ub;
         case (op)
            0: v = ua + ub;
            3: v = ua - ub;
            1: begin v = sa + sb; if (v > hi) v = hi; if (v < lo) v = lo; end
            4: begin v = sa - sb; if (v > hi) v = hi; if (v < lo) v = lo; end
            2: begin v = ua + ub; if (v > longint'(m)) v = longint'(m); end
            5: begin v = ua - ub; if (v < 0) v = 0; end
            6: v = (sh >= lw) ? 0 : (ua << sh);
            7: v = (sh >= lw) ? 0 : (ua >> sh);
            8: v = (sh >= lw) ? ((sa < 0) ? -1 : 0) : (sa >>> sh);
            13: v = (ua == ub) ? -1 : 0;
            14: v = (sa > sb) ? -1 : 0;
            default: v = 0;
         endcase
         r = r | ((64'(v) & m) << (i*lw));
      end
      return r;
   endfunction

   function automatic string req_of(input int op, input int sz);
      if (sz == 3 && (op <= 8 || op == 13 || op == 14 || op == 20 || op == 21)) return "R2";
      case (op)
         0, 3:   return "R2";
         1, 4:   return "R3";
         2, 5:   return "R4";
         6, 7, 8: return "R5";
         9, 10, 11, 12: return "R6";
         13, 14: return "R7";
         15, 16: return "R8";
         17:     return "R9";
         18:     return "R10";
         19:     return "R11";
         20, 21: return "R12";
         default: return "R13";
      endcase
   endfunction

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic run(input int op, input int sz, input logic [63:0] a, input logic [63:0] b);
      logic [63:0] exp;
      @(negedge clk);
      in_valid = 1'b1;
      in_op    = 5'(op);
      in_size  = 2'(sz);
      in_a     = a;
      in_b     = b;
      exp      = model(op, sz, a, b);
      @(negedge clk);
      check("R1", {63'd0, out_valid}, 64'd1);
      check(req_of(op, sz), out_result, exp);
   endtask

   task automatic pattern(input int k, output logic [63:0] a, output logic [63:0] b);
      case (k)
         0:  begin a = 64'h0;                  b = 64'h0; end
         1:  begin a = '1;                     b = '1; end
         2:  begin a = 64'h7F7F7F7F7F7F7F7F;   b = 64'h0101010101010101; end
         3:  begin a = 64'h8080808080808080;   b = 64'h8080808080808080; end
         4:  begin a = 64'h8080808080808080;   b = 64'h0101010101010101; end
         5:  begin a = 64'h0123456789ABCDEF;   b = 64'h0123456789ABCDEF; end
         6:  begin a = 64'hFEDCBA9876543210;   b = 64'h0123456789ABCDEF; end
         7:  begin a = 64'h7FFF80007FFF8000;   b = 64'h80007FFF0001FFFF; end
         8:  begin a = 64'h0000FFFF0000FFFF;   b = 64'h0000000100000001; end
         9:  begin a = 64'h800000007FFFFFFF;   b = 64'h00000001FFFFFFFF; end
         10: begin a = 64'h8000800080008000;   b = 64'h8000800080008000; end
         11: begin a = 64'h00FFFF000080FF7F;   b = 64'h010000FFFF800080; end
         default: begin
            rng = nxt_rand(rng); a = rng;
            rng = nxt_rand(rng); b = rng;
         end
      endcase
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [63:0] a, b, held;
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1", {63'd0, out_valid}, 64'd0);
      check("R1", out_result, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", {63'd0, out_valid}, 64'd0);

      for (int op = 0; op < 24; op++) begin
         for (int sz = 0; sz < 4; sz++) begin
            for (int k = 0; k < 40; k++) begin
               pattern(k, a, b);
               run(op, sz, a, b);
            end
         end
      end

      // R5: shift counts around and past each lane width
      for (int sh = 0; sh <= 40; sh++) begin
         for (int op = 6; op <= 8; op++) begin
            for (int sz = 0; sz < 3; sz++) begin
               rng = nxt_rand(rng);
               run(op, sz, rng | 64'h8000800080008080, {rng[63:8], 8'(sh)});
            end
         end
      end

      // R1: result holds while in_valid is low
      run(0, 0, 64'h0102030405060708, 64'h1010101010101010);
      held = out_result;
      @(negedge clk);
      in_valid = 1'b0;
      in_op    = 5'd11;
      in_a     = 64'hFFFF0000FFFF0000;
      in_b     = 64'h1234123412341234;
      @(negedge clk);
      check("R1", {63'd0, out_valid}, 64'd0);
      check("R1", out_result, held);
      @(negedge clk);
      check("R1", out_result, held);

      finish_run();
   end

endmodule